// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block connects a 32-bit integer register datapath to a byte-addressed 32-bit data memory port. A store of a byte, halfword or word is turned into a word-aligned memory address, a set of per-byte write strobes and lane-replicated write data. A load takes the word that memory returns one cycle later and pulls out the addressed byte, halfword or word. It then widens the item to 32 bits, either with zeros or with copies of its sign bit, as the request selects.

Lanes are mapped big-endian: the byte at the lowest address of a word sits in the most significant lane. Every access must be aligned to its own size. A misaligned request never reaches memory. It is reported by an error flag in the following cycle, and a misaligned load returns zero data.

Top module: `be_lane_aligner`

## Requirements
- R1: A byte store (req_size 00) asserts exactly one strobe: byte offset 00 sets mem_wstrb bit 3 (data bits 31:24), 01 sets bit 2 (bits 23:16), 10 sets bit 1 (bits 15:8), and 11 sets bit 0 (bits 7:0). mem_wdata carries req_wdata[7:0] in all four lanes.
- R2: A halfword store (req_size 01) at offset 00 sets mem_wstrb to 1100, and at offset 10 sets it to 0011. mem_wdata carries req_wdata[15:0] in both halves.
- R3: A word store (req_size 10) at offset 00 sets mem_wstrb to 1111, and mem_wdata equals req_wdata.
- R4: In the request cycle, mem_addr is req_addr with bits 1:0 cleared. mem_req is high for any aligned request, and mem_we is high only for an aligned store (req_wr=1).
- R5: A byte load returns, in rsp_data[7:0], the memory lane chosen by the R1 offset mapping. Bits 31:8 are zero when req_sext=0 and copies of the byte's bit 7 when req_sext=1.
- R6: A halfword load at offset 00 returns mem_rdata[31:16], and at offset 10 returns mem_rdata[15:0], in rsp_data[15:0]. Bits 31:16 are filled with zeros or with the halfword's bit 15, as req_sext selects.
- R7: A word load returns mem_rdata unchanged, whatever the value of req_sext.
- R8: The load result appears in the cycle after the request, with rsp_vld high for exactly that one cycle. mem_rdata is sampled in that same cycle. A store never raises rsp_vld.
- R9: The following requests are misaligned: a halfword with address bit 0 set, a word whose address bits 1:0 are not 00, and any request with req_size 11. For such a request, mem_req, mem_we and all strobes stay low. rsp_err is high for one cycle in the following cycle, and a misaligned load returns rsp_data of zero.
- R10: While reset is held, and in any cycle without a request, rsp_vld, rsp_err, mem_req and mem_wstrb are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Access request this cycle |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_sext | input | 1 | Load fill select: 1 = sign, 0 = zero |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Register value to store |
| mem_req | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wstrb | output | 4 | Byte write strobes, bit 3 = lane 31:24 |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read word, valid one cycle after mem_req |
| rsp_vld | output | 1 | Load result valid |
| rsp_err | output | 1 | Misalignment of the previous request |
| rsp_data | output | 32 | Aligned, filled load result |

## Verification
The bench sweeps every combination of size code, low address bits, direction and fill select. Each combination is run with three data words whose lanes differ in value and in top bit. Because the lane contents are distinct, a swapped or mirrored lane mapping shows up as a wrong value and not as a coincidental match. Because the top bits differ from lane to lane, a fill taken from the wrong bit, or zero fill in place of sign fill, produces different upper bits. The misaligned combinations in the same sweep tell a suppressed access apart from one that was only flagged. After each response, an idle cycle shows that the error flag lasts only one cycle.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = BYTE_W * WORD_BYTES;
  localparam int unsigned OFF_W      = $clog2(WORD_BYTES);
  localparam int unsigned HALF_W     = WORD_W / 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // True when the offset does not suit the access size.
  function automatic logic off_misaligned(acc_size_e sz, logic [OFF_W-1:0] off);
    logic bad;
    case (sz)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = off[0];
      SZ_WORD: bad = (off != '0);
      default: bad = 1'b1;
    endcase
    return bad;
  endfunction

  // Strobe bit i covers data bits i*8+7 : i*8; offset 0 is the top lane.
  function automatic logic [WORD_BYTES-1:0] lane_strobes(acc_size_e sz, logic [OFF_W-1:0] off);
    logic [WORD_BYTES-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_BYTES; i++) begin
      case (sz)
        SZ_BYTE: if (i == int'(WORD_BYTES-1) - int'(off)) m[i] = 1'b1;
        SZ_HALF: if ((i >= int'(WORD_BYTES/2)) == !off[OFF_W-1]) m[i] = 1'b1;
        SZ_WORD: m[i] = 1'b1;
        default: m[i] = 1'b0;
      endcase
    end
    return m;
  endfunction

  // Copies the low item of the register value into every lane it may use.
  function automatic logic [WORD_W-1:0] replicate_item(acc_size_e sz, logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    case (sz)
      SZ_BYTE: r = {WORD_BYTES{d[BYTE_W-1:0]}};
      SZ_HALF: r = {2{d[HALF_W-1:0]}};
      default: r = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/be_req_decode.sv
module be_req_decode
  import be_lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              req_vld,
  input  logic              req_wr,
  input  acc_size_e         req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              misaligned,
  output logic              go,
  output logic              go_wr,
  output logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] word_addr
);
  always_comb begin
    offset     = req_addr[OFF_W-1:0];
    misaligned = req_vld && off_misaligned(req_size, offset);
    go         = req_vld && !misaligned;
    go_wr      = go && req_wr;
    word_addr  = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  end
endmodule

// File: rtl/be_store_lanes.sv
module be_store_lanes
  import be_lsu_pkg::*;
(
  input  logic                  active,
  input  acc_size_e             size,
  input  logic [OFF_W-1:0]      offset,
  input  logic [WORD_W-1:0]     reg_data,
  output logic [WORD_BYTES-1:0] strobes,
  output logic [WORD_W-1:0]     lane_data
);
  always_comb begin
    strobes   = active ? lane_strobes(size, offset) : '0;
    lane_data = replicate_item(size, reg_data);
  end
endmodule

// File: rtl/be_load_extract.sv
module be_load_extract
  import be_lsu_pkg::*;
(
  input  logic [WORD_W-1:0] rdata,
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  offset,
  input  logic              sext,
  output logic [WORD_W-1:0] value
);
  localparam int unsigned BFILL_W = WORD_W - BYTE_W;
  localparam int unsigned HFILL_W = WORD_W - HALF_W;

  // by_off[k] is the byte stored at offset k (big-endian lanes).
  logic [BYTE_W-1:0] by_off [WORD_BYTES];
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign by_off[g] = rdata[(WORD_BYTES-1-g)*BYTE_W +: BYTE_W];
  end

  logic [BYTE_W-1:0] byte_item;
  logic [HALF_W-1:0] half_item;

  always_comb begin
    byte_item = by_off[offset];
    half_item = {by_off[{offset[OFF_W-1], 1'b0}], by_off[{offset[OFF_W-1], 1'b1}]};
    case (size)
      SZ_BYTE: value = {{BFILL_W{sext & byte_item[BYTE_W-1]}}, byte_item};
      SZ_HALF: value = {{HFILL_W{sext & half_item[HALF_W-1]}}, half_item};
      SZ_WORD: value = rdata;
      default: value = '0;
    endcase
  end
endmodule

// File: rtl/be_lane_aligner.sv
module be_lane_aligner
  import be_lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_vld,
  input  logic                  req_wr,
  input  logic [1:0]            req_size,
  input  logic                  req_sext,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [WORD_W-1:0]     req_wdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [WORD_BYTES-1:0] mem_wstrb,
  output logic [WORD_W-1:0]     mem_wdata,
  input  logic [WORD_W-1:0]     mem_rdata,
  output logic                  rsp_vld,
  output logic                  rsp_err,
  output logic [WORD_W-1:0]     rsp_data
);
  acc_size_e        size_in;
  logic             req_misaligned;
  logic             req_go;
  logic             req_go_wr;
  logic [OFF_W-1:0] req_off;
  logic [WORD_W-1:0] extracted;

  assign size_in = acc_size_e'(req_size);

  be_req_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_vld    (req_vld),
    .req_wr     (req_wr),
    .req_size   (size_in),
    .req_addr   (req_addr),
    .misaligned (req_misaligned),
    .go         (req_go),
    .go_wr      (req_go_wr),
    .offset     (req_off),
    .word_addr  (mem_addr)
  );

  be_store_lanes u_st (
    .active    (req_go_wr),
    .size      (size_in),
    .offset    (req_off),
    .reg_data  (req_wdata),
    .strobes   (mem_wstrb),
    .lane_data (mem_wdata)
  );

  assign mem_req = req_go;
  assign mem_we  = req_go_wr;

  // Load context held for the response cycle.
  acc_size_e        ld_size_q;
  logic [OFF_W-1:0] ld_off_q;
  logic             ld_sext_q;
  logic             rsp_vld_q;
  logic             rsp_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q <= 1'b0;
      rsp_err_q <= 1'b0;
      ld_size_q <= SZ_BYTE;
      ld_off_q  <= '0;
      ld_sext_q <= 1'b0;
    end else begin
      rsp_vld_q <= req_vld && !req_wr;
      rsp_err_q <= req_misaligned;
      if (req_vld && !req_wr) begin
        ld_size_q <= size_in;
        ld_off_q  <= req_off;
        ld_sext_q <= req_sext;
      end
    end
  end

  be_load_extract u_ld (
    .rdata  (mem_rdata),
    .size   (ld_size_q),
    .offset (ld_off_q),
    .sext   (ld_sext_q),
    .value  (extracted)
  );

  assign rsp_vld  = rsp_vld_q;
  assign rsp_err  = rsp_err_q;
  assign rsp_data = (rsp_vld_q && !rsp_err_q) ? extracted : '0;
endmodule

// File: rtl/be_lsu_chk.sv
module be_lsu_chk
  import be_lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_vld,
  input logic                  req_wr,
  input logic [1:0]            req_size,
  input logic                  req_sext,
  input logic [ADDR_W-1:0]     req_addr,
  input logic                  req_misaligned,
  input logic                  mem_req,
  input logic                  mem_we,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic [WORD_BYTES-1:0] mem_wstrb,
  input logic                  rsp_vld,
  input logic                  rsp_err,
  input logic [WORD_W-1:0]     rsp_data
);
  // R9
  mis_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_misaligned) |-> (mem_wstrb == '0 && !mem_req && !mem_we));
  // R9
  mis_err_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_size == 2'b10 && req_addr[1:0] != 2'b00) |=> rsp_err);
  // R9
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_err) |-> (rsp_data == '0));
  // R4
  word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00 && mem_addr[ADDR_W-1:2] == req_addr[ADDR_W-1:2]));
  // R1
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == 2'b00) |-> ($countones(mem_wstrb) == 1));
  // R8
  load_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_wr) |=> rsp_vld);
  // R8
  store_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_wr) |=> !rsp_vld);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |-> (mem_wstrb == '0 && !mem_req));
  // R5
  byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_wr && req_size == 2'b00 && !req_sext) |=> (rsp_data[WORD_W-1:BYTE_W] == '0));
endmodule

bind be_lane_aligner be_lsu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_vld        (req_vld),
  .req_wr         (req_wr),
  .req_size       (req_size),
  .req_sext       (req_sext),
  .req_addr       (req_addr),
  .req_misaligned (req_misaligned),
  .mem_req        (mem_req),
  .mem_we         (mem_we),
  .mem_addr       (mem_addr),
  .mem_wstrb      (mem_wstrb),
  .rsp_vld        (rsp_vld),
  .rsp_err        (rsp_err),
  .rsp_data       (rsp_data)
);

// File: tb/sim_be_lane_aligner.sv
`timescale 1ns/1ps
module sim_be_lane_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0, req_wr = 1'b0, req_sext = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
  logic        mem_req, mem_we, rsp_vld, rsp_err;
  logic [31:0] mem_addr, mem_wdata, rsp_data;
  logic [3:0]  mem_wstrb;

  int checks = 0, fails = 0;
  bit timeout = 0;

  always #4 clk = ~clk;

  be_lane_aligner u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string size_req(int sz, bit ld);
    case (sz)
      0: return ld ? "R5" : "R1";
      1: return ld ? "R6" : "R2";
      2: return ld ? "R7" : "R3";
      default: return "R9";
    endcase
  endfunction

  function automatic bit is_mis(int sz, int off);
    return (sz == 3) || (sz == 1 && (off % 2) == 1) || (sz == 2 && off != 0);
  endfunction

  function automatic logic [31:0] exp_load(int sz, int off, bit sx, logic [31:0] w);
    logic [31:0] v;
    case (sz)
      0: begin
        v = (w >> ((3 - off) * 8)) & 32'hFF;
        if (sx && v[7]) v = v | 32'hFFFF_FF00;
      end
      1: begin
        v = (w >> ((2 - off) * 8)) & 32'hFFFF;
        if (sx && v[15]) v = v | 32'hFFFF_0000;
      end
      default: v = w;
    endcase
    return v;
  endfunction

  task automatic access(int sz, int off, bit wr, bit sx, logic [31:0] pat);
    logic [31:0] wd, base, exp_strb, exp_wd;
    bit mis;
    mis  = is_mis(sz, off);
    wd   = {pat[15:0], pat[31:16]} ^ 32'h5A3C_96E1;
    base = 32'h4000_1230 + 32'(off);
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr; req_size = 2'(sz); req_sext = sx;
    req_addr = base; req_wdata = wd;
    #1;
    exp_strb = 0; exp_wd = wd;
    if (!mis && wr) begin
      case (sz)
        0: begin exp_strb = 32'(1) << (3 - off); exp_wd = 32'(wd[7:0]) * 32'h0101_0101; end
        1: begin exp_strb = 32'(3) << (2 - off); exp_wd = 32'(wd[15:0]) * 32'h0001_0001; end
        default: exp_strb = 15;
      endcase
    end
    chk(mis ? "R9 strobes" : size_req(sz, 0), {28'd0, mem_wstrb}, exp_strb);
    if (!mis && wr) chk(size_req(sz, 0), mem_wdata, exp_wd);
    chk("R4 mem_req", {31'd0, mem_req}, {31'd0, !mis});
    chk("R4 mem_we", {31'd0, mem_we}, {31'd0, !mis && wr});
    if (!mis) chk("R4 mem_addr", mem_addr, base & 32'hFFFF_FFFC);
    @(negedge clk);
    req_vld = 1'b0;
    mem_rdata = pat;
    #1;
    chk("R8 rsp_vld", {31'd0, rsp_vld}, {31'd0, !wr});
    chk("R9 rsp_err", {31'd0, rsp_err}, {31'd0, mis});
    if (!wr) chk(mis ? "R9 data" : size_req(sz, 1), rsp_data, mis ? 32'd0 : exp_load(sz, off, sx, pat));
    @(negedge clk);
    #1;
    chk("R9 err one cycle", {31'd0, rsp_err}, 32'd0);
    chk("R8 vld one cycle", {31'd0, rsp_vld}, 32'd0);
  endtask

  task automatic run();
    logic [31:0] pats [3];
    pats[0] = 32'h81C2_73F4;
    pats[1] = 32'h7F00_80FF;
    pats[2] = 32'h0123_4567;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk("R10 rsp_vld in reset", {31'd0, rsp_vld}, 32'd0);
    chk("R10 rsp_err in reset", {31'd0, rsp_err}, 32'd0);
    chk("R10 strobes idle", {28'd0, mem_wstrb}, 32'd0);
    chk("R10 mem_req idle", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 idle after reset", {30'd0, rsp_vld, rsp_err}, 32'd0);
    for (int p = 0; p < 3; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int wr = 0; wr < 2; wr++)
            for (int sx = 0; sx < 2; sx++)
              access(sz, off, wr[0], sx[0], pats[p]);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) begin
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule